// File: doc/BRIEF.md
# Change-of-State Digital I/O Controller

This block is the register core of a 56-line digital I/O card. It holds 24 latched output lines, samples 24 isolated input lines, and owns one 8-line TTL bank whose pins are either driven from a latch or read as inputs, depending on a mode bit in the control byte. The 24 isolated inputs and the 8 TTL pins together form 32 change-of-state lines, grouped into four banks of eight. Each bank can independently flag rising edges, falling edges or both. Every detected edge latches a per-line status bit. The interrupt output stays high while any status bit is set.

The host reaches sixteen byte registers over a simple synchronous port. A byte access moves the low eight data bits. A word access (`bus_wide` high) covers the four registers of the aligned word at `bus_addr[3:2]`, little-endian, so all 32 status bits can be read or cleared in one operation. Read data is registered and appears one clock after the address. Any write that reaches offset 15 performs a software board reset.

Top module: `cos_dio_ctrl`

## Requirements
- R1: After `rst`, every output latch, the control byte (offset 12) and the enable byte (offset 14) read 0, `ttl_oe` is 0, `irq` is 0 and all status bits are 0.
- R2: Offsets 0, 1 and 2 hold output lines 0–7, 8–15 and 16–23 on `out_fet`, and offset 3 holds the TTL latch on `ttl_out`. All four read back what was last written.
- R3: Offsets 4–6 return isolated inputs 0–23 and offset 7 returns the TTL pins, each after a two-flop synchronizer. Writes to offsets 4–7 change nothing. Offset 13 reads 0 and ignores writes.
- R4: Bit 1 of the control byte at offset 12 drives `ttl_oe`, where 1 selects output mode. The whole byte reads back.
- R5: Bit n (n = 0..3) of the enable byte makes a 0-to-1 transition on any line of bank n set that line's status bit. Bank 0 is inputs 0–7, bank 1 is 8–15, bank 2 is 16–23 and bank 3 is the TTL pins.
- R6: Bit n+4 of the enable byte makes a 1-to-0 transition on any line of bank n set that line's status bit.
- R7: A write to offsets 8–11 clears every status bit written as 1 and leaves every bit written as 0 unchanged. A set bit otherwise stays set.
- R8: A word access at offset 8 reads the 32 status bits with bit k = line k (isolated 0–23, TTL lines at 24–31) and clears them with the same layout.
- R9: `irq` is high exactly while at least one status bit is set, and bit 0 of offset 15 returns `irq`.
- R10: If an enabled edge on a line arrives in the same cycle as a clear of that line's status bit, the bit stays set.
- R11: A write of any value to offset 15 clears the output latches, the control byte, the enable byte and all status bits. This leaves the TTL bank in input mode.
- R12: An edge whose type is not enabled for its bank sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_we | input | 1 | Write strobe |
| bus_wide | input | 1 | 1 = 32-bit access to the aligned word, 0 = byte access |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 32 | Write data (bits 7:0 for byte access) |
| bus_rdata | output | 32 | Registered read data, one clock after the address |
| iso_in | input | 24 | Isolated input lines |
| ttl_in | input | 8 | TTL pin levels as seen from outside |
| out_fet | output | 24 | Latched output lines |
| ttl_out | output | 8 | TTL output latch |
| ttl_oe | output | 1 | TTL bank drive enable (output mode) |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
Two functions can land on the same status bit in the same clock: a host write-one clear and a freshly detected enabled edge. The bench first sets a bit. It then changes the pin two clocks before the clear write is sampled, which places the edge detector's output and the clear at the same rising edge. The bit must read back as set. A second run uses the same clear with no edge, and the bit must read as cleared, which shows that the first result came from the collision and not from a broken clear.

// File: rtl/cos_dio_pkg.sv
`timescale 1ns/1ps
package cos_dio_pkg;
  localparam int BYTE_W       = 8;
  localparam int NUM_OUT_B    = 3;                 // latched output bytes
  localparam int NUM_ISO_B    = 3;                 // isolated input bytes
  localparam int NUM_BANKS    = NUM_ISO_B + 1;     // isolated banks + TTL bank
  localparam int COS_W        = NUM_BANKS * BYTE_W;
  localparam int NUM_REGS     = 16;
  localparam int TTL_MODE_BIT = 1;

  localparam logic [3:0] OFS_OUT0  = 4'd0;
  localparam logic [3:0] OFS_TTLO  = 4'd3;
  localparam logic [3:0] OFS_IN0   = 4'd4;
  localparam logic [3:0] OFS_TTLI  = 4'd7;
  localparam logic [3:0] OFS_STAT0 = 4'd8;
  localparam logic [3:0] OFS_CTL   = 4'd12;
  localparam logic [3:0] OFS_RSVD  = 4'd13;
  localparam logic [3:0] OFS_EN    = 4'd14;
  localparam logic [3:0] OFS_SWRST = 4'd15;
endpackage

// File: rtl/dio_sync.sv
`timescale 1ns/1ps
module dio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cos_bank.sv
`timescale 1ns/1ps
module cos_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wipe,      // hard or software reset
  input  logic [W-1:0] smp,       // synchronized line levels
  input  logic         rise_en,
  input  logic         fall_en,
  input  logic [W-1:0] clr_mask,  // write-one-to-clear bits
  output logic [W-1:0] stat,
  output logic [W-1:0] stat_nxt
);
  logic [W-1:0] prev_q;
  logic [W-1:0] evt;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= smp;
  end

  always_comb begin
    evt = '0;
    if (rise_en) evt = evt | (smp & ~prev_q);
    if (fall_en) evt = evt | (~smp & prev_q);
    // a new event wins over a clear of the same bit
    stat_nxt = wipe ? '0 : ((stat & ~clr_mask) | evt);
  end

  always_ff @(posedge clk) begin
    stat <= stat_nxt;
  end
endmodule

// File: rtl/cos_dio_ctrl.sv
`timescale 1ns/1ps
module cos_dio_ctrl
  import cos_dio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_we,
  input  logic                          bus_wide,
  input  logic [3:0]                    bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_ISO_B*BYTE_W-1:0]   iso_in,
  input  logic [BYTE_W-1:0]             ttl_in,
  output logic [NUM_OUT_B*BYTE_W-1:0]   out_fet,
  output logic [BYTE_W-1:0]             ttl_out,
  output logic                          ttl_oe,
  output logic                          irq
);
  localparam int NUM_LATCH = NUM_OUT_B + 1;

  logic [NUM_REGS-1:0] wr_hit;
  logic [BYTE_W-1:0]   wr_byte [NUM_REGS];
  logic [BYTE_W-1:0]   out_q   [NUM_LATCH];
  logic [BYTE_W-1:0]   ctl_q;
  logic [BYTE_W-1:0]   en_q;
  logic                irq_q;
  logic                wipe;
  logic [COS_W-1:0]    smp;
  logic [COS_W-1:0]    stat_all;
  logic [COS_W-1:0]    stat_nxt_all;
  logic [COS_W-1:0]    clr_all;
  logic [BYTE_W-1:0]   view [NUM_REGS];
  logic [31:0]         rd_nxt;

  // write decode: byte lane per register, word access covers aligned group
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      logic [3:0] idx;
      idx = 4'(i);
      wr_hit[i]  = bus_we && (bus_wide ? (bus_addr[3:2] == idx[3:2])
                                       : (bus_addr == idx));
      wr_byte[i] = bus_wide ? bus_wdata[8*idx[1:0] +: 8] : bus_wdata[7:0];
    end
  end

  assign wipe = rst | wr_hit[OFS_SWRST];

  // output latches (FET bytes then TTL latch)
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_LATCH; i++) begin
      if (wipe)                       out_q[i] <= '0;
      else if (wr_hit[OFS_OUT0 + i])  out_q[i] <= wr_byte[OFS_OUT0 + i];
    end
  end

  always_ff @(posedge clk) begin
    if (wipe) begin
      ctl_q <= '0;
      en_q  <= '0;
    end else begin
      if (wr_hit[OFS_CTL]) ctl_q <= wr_byte[OFS_CTL];
      if (wr_hit[OFS_EN])  en_q  <= wr_byte[OFS_EN];
    end
  end

  dio_sync #(.WIDTH(COS_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({ttl_in, iso_in}),
    .dout (smp)
  );

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign clr_all[b*BYTE_W +: BYTE_W] =
        wr_hit[OFS_STAT0 + b] ? wr_byte[OFS_STAT0 + b] : '0;

      cos_bank #(.W(BYTE_W)) i_bank (
        .clk      (clk),
        .rst      (rst),
        .wipe     (wipe),
        .smp      (smp[b*BYTE_W +: BYTE_W]),
        .rise_en  (en_q[b]),
        .fall_en  (en_q[b + NUM_BANKS]),
        .clr_mask (clr_all[b*BYTE_W +: BYTE_W]),
        .stat     (stat_all[b*BYTE_W +: BYTE_W]),
        .stat_nxt (stat_nxt_all[b*BYTE_W +: BYTE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    irq_q <= |stat_nxt_all;
  end

  // read view of the sixteen registers
  always_comb begin
    for (int i = 0; i < NUM_LATCH; i++) view[OFS_OUT0 + i] = out_q[i];
    for (int i = 0; i < NUM_BANKS; i++) begin
      view[OFS_IN0 + i]   = smp[i*BYTE_W +: BYTE_W];
      view[OFS_STAT0 + i] = stat_all[i*BYTE_W +: BYTE_W];
    end
    view[OFS_CTL]   = ctl_q;
    view[OFS_RSVD]  = '0;
    view[OFS_EN]    = en_q;
    view[OFS_SWRST] = {7'd0, irq_q};
  end

  always_comb begin
    if (bus_wide)
      rd_nxt = {view[{bus_addr[3:2], 2'd3}], view[{bus_addr[3:2], 2'd2}],
                view[{bus_addr[3:2], 2'd1}], view[{bus_addr[3:2], 2'd0}]};
    else
      rd_nxt = {24'd0, view[bus_addr]};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end

  generate
    for (b = 0; b < NUM_OUT_B; b++) begin : g_out
      assign out_fet[b*BYTE_W +: BYTE_W] = out_q[b];
    end
  endgenerate

  assign ttl_out = out_q[NUM_OUT_B];
  assign ttl_oe  = ctl_q[TTL_MODE_BIT];
  assign irq     = irq_q;
endmodule

// File: rtl/cos_dio_chk.sv
`timescale 1ns/1ps
module cos_dio_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_we,
  input logic        bus_wide,
  input logic [3:0]  bus_addr,
  input logic [23:0] out_fet,
  input logic        ttl_oe,
  input logic        irq,
  input logic [31:0] stat,
  input logic [7:0]  en
);
  AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq == (|stat)); // R9

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|($past(stat) & ~stat)) |-> $past(bus_we)); // R7

  AST_NEW_BIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (|(stat & ~$past(stat))) |-> ($past(en) != 8'd0)); // R12

  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !bus_wide && bus_addr == 4'hF) |=>
      (out_fet == 24'd0 && !ttl_oe && !irq)); // R11

  AST_MODE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$stable(ttl_oe) |-> $past(bus_we)); // R4
endmodule

bind cos_dio_ctrl cos_dio_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_we   (bus_we),
  .bus_wide (bus_wide),
  .bus_addr (bus_addr),
  .out_fet  (out_fet),
  .ttl_oe   (ttl_oe),
  .irq      (irq),
  .stat     (stat_all),
  .en       (en_q)
);

// File: tb/test_cos_dio_ctrl.sv
`timescale 1ns/1ps
module test_cos_dio_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_wide = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [23:0] iso_in = 24'd0;
  logic [7:0]  ttl_in = 8'd0;
  logic [23:0] out_fet;
  logic [7:0]  ttl_out;
  logic        ttl_oe;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cos_dio_ctrl i_cos_dio_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .iso_in(iso_in), .ttl_in(ttl_in), .out_fet(out_fet), .ttl_out(ttl_out),
    .ttl_oe(ttl_oe), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic w);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = w;
    @(negedge clk);
    bus_we = 1'b0; bus_wide = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic w, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wide = w;
    @(negedge clk);
    d = bus_rdata;
    bus_wide = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] bank_mask(input logic [3:0] sel);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = sel[b] ? 8'hFF : 8'h00;
    return m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] p;
    logic [31:0] ex;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check({31'd0, ttl_oe}, 0, "R1 ttl_oe");
    check({31'd0, irq}, 0, "R1 irq");
    check({out_fet, ttl_out}, 0, "R1 latches");
    rd(4'd0, 1'b1, d);  check(d, 0, "R1 outputs word");
    rd(4'd12, 1'b1, d); check(d, 0, "R1 ctl/en word");
    rd(4'd8, 1'b1, d);  check(d, 0, "R1 status word");

    // R2 output latches, sweep byte values
    for (int i = 0; i < 4; i++) begin
      for (int v = 0; v < 256; v += 37) begin
        logic [7:0] bv;
        bv = 8'(v) ^ 8'(i * 8'h55);
        wr(4'(i), {24'hFFFFFF, bv}, 1'b0);
        rd(4'(i), 1'b0, d);
        check(d, {24'd0, bv}, "R2 readback");
        if (i < 3) check({24'd0, out_fet[8*i +: 8]}, {24'd0, bv}, "R2 out_fet");
        else       check({24'd0, ttl_out}, {24'd0, bv}, "R2 ttl_out");
      end
    end
    wr(4'd0, 32'h8C_3A_51_E7, 1'b1);
    check({ttl_out, out_fet}, 32'h8C_3A_51_E7, "R2 word write");

    // R3 input view and read-only behaviour
    iso_in = 24'hC4_A2_17; ttl_in = 8'h69;
    settle();
    rd(4'd4, 1'b1, d); check(d, 32'h69_C4_A2_17, "R3 input word");
    rd(4'd5, 1'b0, d); check(d, 32'h0000_00A2, "R3 input byte");
    wr(4'd4, 32'h0, 1'b1);
    wr(4'd7, 32'h5A, 1'b0);
    rd(4'd4, 1'b1, d); check(d, 32'h69_C4_A2_17, "R3 writes ignored");
    wr(4'd13, 32'hFF, 1'b0);
    rd(4'd13, 1'b0, d); check(d, 0, "R3 reserved reads 0");
    iso_in = 24'd0; ttl_in = 8'd0;
    settle();

    // R4 mode bit
    wr(4'd12, 32'h02, 1'b0);
    check({31'd0, ttl_oe}, 1, "R4 output mode");
    rd(4'd12, 1'b0, d); check(d, 32'h02, "R4 ctl readback");
    wr(4'd12, 32'hFD, 1'b0);
    check({31'd0, ttl_oe}, 0, "R4 input mode");
    rd(4'd12, 1'b0, d); check(d, 32'hFD, "R4 ctl readback 2");
    wr(4'd12, 32'h00, 1'b0);

    // R5 R6 R12 R8 R9: sweep all enable values
    for (int e = 0; e < 256; e++) begin
      logic [7:0] en;
      en = 8'(e);
      p = {8'hA5 ^ en, 8'h3C + en, 8'hC3 ^ en, 8'h5A + en};
      wr(4'd14, {24'd0, en}, 1'b0);
      wr(4'd8, 32'hFFFF_FFFF, 1'b1);
      iso_in = p[23:0]; ttl_in = p[31:24];
      settle();
      ex = p & bank_mask(en[3:0]);
      rd(4'd8, 1'b1, d); check(d, ex, "R5 R12 rising");
      check({31'd0, irq}, {31'd0, ex != 0}, "R9 irq rising");
      wr(4'd8, 32'hFFFF_FFFF, 1'b1);
      iso_in = 24'd0; ttl_in = 8'd0;
      settle();
      ex = p & bank_mask(en[7:4]);
      rd(4'd8, 1'b1, d); check(d, ex, "R6 R12 falling");
      rd(4'd15, 1'b0, d); check(d, {31'd0, ex != 0}, "R9 offset 15");
    end

    // R7 R8 partial clears, byte and word
    wr(4'd14, 32'h0F, 1'b0);
    wr(4'd8, 32'hFFFF_FFFF, 1'b1);
    iso_in = 24'hFFFFFF; ttl_in = 8'hFF;
    settle();
    wr(4'd9, 32'h0F, 1'b0);
    rd(4'd8, 1'b1, d); check(d, 32'hFFFF_F0FF, "R7 byte clear");
    rd(4'd11, 1'b0, d); check(d, 32'hFF, "R8 byte view of TTL bank");
    wr(4'd8, 32'h00FF_00FF, 1'b1);
    rd(4'd8, 1'b1, d); check(d, 32'hFF00_F000, "R8 word clear");
    check({31'd0, irq}, 1, "R9 irq held");
    wr(4'd8, 32'hFF00_F000, 1'b1);
    check({31'd0, irq}, 0, "R9 irq drops");

    // R10 clear collides with new edge on the same bit
    wr(4'd14, 32'h11, 1'b0);
    iso_in = 24'd0; ttl_in = 8'd0;
    settle();
    wr(4'd8, 32'hFFFF_FFFF, 1'b1);
    iso_in[0] = 1'b1;
    settle();
    rd(4'd8, 1'b0, d); check(d, 32'h01, "R10 setup");
    @(negedge clk);
    iso_in[0] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'd8; bus_wdata = 32'h01; bus_wide = 1'b0;
    @(negedge clk);
    bus_we = 1'b0;
    settle();
    rd(4'd8, 1'b0, d); check(d, 32'h01, "R10 edge beats clear");
    wr(4'd8, 32'h01, 1'b0);
    rd(4'd8, 1'b0, d); check(d, 32'h00, "R7 clear without edge");

    // R11 software reset
    wr(4'd0, 32'h12_34_56_78, 1'b1);
    wr(4'd12, 32'h02, 1'b0);
    wr(4'd14, 32'hFF, 1'b0);
    ttl_in = 8'h81;
    settle();
    check({31'd0, irq}, 1, "R11 setup irq");
    wr(4'd15, 32'h00, 1'b0);
    check({ttl_out, out_fet}, 0, "R11 latches");
    check({31'd0, ttl_oe}, 0, "R11 input mode");
    check({31'd0, irq}, 0, "R11 irq");
    rd(4'd12, 1'b1, d); check(d, 0, "R11 ctl/en");
    rd(4'd8, 1'b1, d);  check(d, 0, "R11 status");
    ttl_in = 8'h00;
    settle();
    rd(4'd8, 1'b1, d);  check(d, 0, "R12 no detect after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule